// File: doc/BRIEF.md
# Dot-Matrix LCD Scan Timing Generator

This block drives the row and column scanning of a character dot-matrix liquid-crystal panel. It runs from the oscillator clock. It selects one common (row) line at a time at a duty of 1/8, 1/11 or 1/16, set by the line-count and font-height controls. It measures each row's selection time in oscillator clocks, and it builds the dot pattern for the coming row. The dots are shifted serially: the first `SEG_BITS` dots settle in an internal shift register, and all further dots continue out on a serial pin to a cascaded extension driver. At the row boundary the internal register is copied into the segment latch, and a latch pulse tells the extension driver to do the same.

Character patterns come from an external font lookup. The block presents a character column, text line and cell row, and reads back a row of `CELL_COLS` dots in the same cycle. On top of the glyph the block draws a cursor underline, a blinking solid cell and display blanking. It also produces the polarity-alternation signal in one of two waveform variants. Mode inputs are meant to change only while reset is held.

Top module: `lcd_scan_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `com_o` is 1 (first common only), `seg_o` is all zero, and `m_o`, `ext_shift_o`, `ext_latch_o` and `ext_data_o` are 0.
- R2: Exactly one bit of `com_o` is high at any time. The active bit moves from bit k to bit k+1 at each row boundary and returns to bit 0 after the last common. There are 8 commons with `two_line_i`=0 and `tall_font_i`=0, 11 with `two_line_i`=0 and `tall_font_i`=1, and 16 with `two_line_i`=1.
- R3: A row lasts `LONG_PERIOD` clocks (default 400) in 1-line modes and `SHORT_PERIOD` clocks (default 200) in 2-line mode. Counting edges from reset release as t=0,1,…, row boundaries fall at edges t where (t+1) is a multiple of the period.
- R4: While common k is active (after the first row), `seg_o[j]` is dot j of scan row k. Dot j belongs to character column j/`CELL_COLS` and is bit (`CELL_COLS`-1-j%`CELL_COLS`) of `glyph_i`, so the leftmost dot is the MSB. In 2-line mode scan row k is text line k/8, cell row k%8. In 1-line modes it is text line 0, cell row k. `font_col_o`/`font_line_o`/`font_row_o` carry that address when each dot is fetched.
- R5: Dots `SEG_BITS` and beyond leave serially on `ext_data_o`, one per rising edge of `ext_shift_o`. An extension register that shifts each received bit into bit 0 and moves older bits up holds dot `SEG_BITS`+j in bit j when `ext_latch_o` rises.
- R6: `ext_shift_o` runs at half the clock rate. It is high in the cycle after every odd count below 2×(`SEG_BITS`+`EXT_BITS`) in the row and never high for two cycles running.
- R7: `ext_latch_o` is a one-cycle pulse, high in exactly the cycle in which `com_o` takes its new value. `com_o` never changes without it.
- R8: `ext_data_o` only changes in cycles where `ext_shift_o` is low, so it is stable at every rising edge of `ext_shift_o`.
- R9: With `wave_b_i`=0, `m_o` toggles at every row boundary. With `wave_b_i`=1 it toggles only at frame boundaries, when the scan wraps to the first common.
- R10: With `disp_on_i`=0, every segment and extension dot is 0 whatever the glyph, cursor or blink settings.
- R11: With `cursor_on_i`=1, all dots of the last cell row (row 7 for 5×8 cells, row 10 for 5×11) are forced to 1 in the cell at `cursor_col_i`/`cursor_line_i`.
- R12: With `blink_on_i`=1, the cursor cell shows all dots on during the on phase of the blink. The phase starts off at reset and flips every `BLINK_FRAMES` frames, so frame f is in the on phase when (f/`BLINK_FRAMES`) is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| two_line_i | input | 1 | 1: two text lines, 1/16 duty |
| tall_font_i | input | 1 | 1-line mode only: 1 selects 5×11 cells, 1/11 duty |
| wave_b_i | input | 1 | Alternation variant: 0 per row, 1 per frame |
| disp_on_i | input | 1 | Display enable; 0 blanks all dots |
| cursor_on_i | input | 1 | Underline cursor enable |
| blink_on_i | input | 1 | Blinking solid cursor cell enable |
| cursor_col_i | input | CW | Cursor character column, CW = clog2((SEG_BITS+EXT_BITS)/CELL_COLS) |
| cursor_line_i | input | 1 | Cursor text line |
| font_col_o | output | CW | Character column of the dot being fetched |
| font_line_o | output | 1 | Text line of the dot being fetched |
| font_row_o | output | 4 | Cell row of the dot being fetched |
| glyph_i | input | CELL_COLS | Dot row returned by the font lookup, leftmost dot in MSB |
| com_o | output | 16 | One-hot common select |
| seg_o | output | SEG_BITS | Latched segment dots |
| ext_data_o | output | 1 | Serial dot data to extension drivers |
| ext_shift_o | output | 1 | Extension shift clock |
| ext_latch_o | output | 1 | Extension latch pulse, once per row |
| m_o | output | 1 | Polarity-alternation signal |

## Verification
The bench sweeps every clock of several whole frames in each duty mode. Every common, shift clock, latch pulse and alternation value is compared with counts derived from t and the period. These patterns separate the 400- and 200-clock periods and the 8-, 11- and 16-common wrap points. At each row boundary the segment latch and a modelled extension register are compared with dots computed from an arithmetic font. The font varies with column, line and row, so dot-order reversals, wrong row mapping and swapped text lines all show up. Separate runs put the cursor in different cells and lines, with underline only, blink only, both, or the display off. This tells apart the last-row underline for 5×8 and 5×11 cells, the blink phase over several blink periods, and blanking.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int MAX_COM = 16;

  // Number of commons scanned for the chosen line count and cell height.
  function automatic logic [4:0] com_count(input logic two_line, input logic tall);
    if (two_line)  return 5'd16;
    else if (tall) return 5'd11;
    else           return 5'd8;
  endfunction

  // Cell row that carries the underline cursor.
  function automatic logic [3:0] underline_row(input logic two_line, input logic tall);
    return (tall && !two_line) ? 4'd10 : 4'd7;
  endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int LONG_PERIOD  = 400,
  parameter int SHORT_PERIOD = 200,
  parameter int BLINK_FRAMES = 32,
  localparam int PW = $clog2(LONG_PERIOD),
  localparam int FW = $clog2(BLINK_FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               two_line,
  input  logic               tall,
  input  logic               wave_b,
  output logic [PW-1:0]      pcnt,
  output logic [4:0]         next_row,
  output logic               row_end,
  output logic               blink_ph,
  output logic [MAX_COM-1:0] com,
  output logic               m,
  output logic               latch
);

  logic [PW-1:0] period;
  logic [4:0]    ncom;
  logic [4:0]    row;
  logic [FW-1:0] fcnt;
  logic          frame_end;

  always_comb begin
    period    = two_line ? PW'(SHORT_PERIOD) : PW'(LONG_PERIOD);
    ncom      = com_count(two_line, tall);
    row_end   = (pcnt == period - PW'(1));
    frame_end = row_end && (row == ncom - 5'd1);
    next_row  = (row == ncom - 5'd1) ? 5'd0 : row + 5'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt     <= '0;
      row      <= '0;
      com      <= MAX_COM'(1);
      m        <= 1'b0;
      latch    <= 1'b0;
      fcnt     <= '0;
      blink_ph <= 1'b0;
    end else begin
      latch <= row_end;
      pcnt  <= row_end ? '0 : pcnt + PW'(1);
      if (row_end) begin
        row <= next_row;
        com <= frame_end ? MAX_COM'(1) : com << 1;
        if (!wave_b || frame_end) m <= ~m;
      end
      if (frame_end) begin
        if (fcnt == FW'(BLINK_FRAMES - 1)) begin
          fcnt     <= '0;
          blink_ph <= ~blink_ph;
        end else begin
          fcnt <= fcnt + FW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lcd_dot_composer.sv
module lcd_dot_composer
  import lcd_scan_pkg::*;
#(
  parameter int TOT       = 80,
  parameter int CELL_COLS = 5,
  parameter int PW        = 9,
  localparam int CW = $clog2(TOT / CELL_COLS),
  localparam int DW = $clog2(TOT),
  localparam int SW = $clog2(CELL_COLS)
) (
  input  logic [PW-1:0]        pcnt,
  input  logic [4:0]           next_row,
  input  logic                 two_line,
  input  logic                 tall,
  input  logic                 disp_on,
  input  logic                 cursor_on,
  input  logic                 blink_on,
  input  logic                 blink_ph,
  input  logic [CW-1:0]        cursor_col,
  input  logic                 cursor_line,
  input  logic [CELL_COLS-1:0] glyph,
  output logic [CW-1:0]        font_col,
  output logic                 font_line,
  output logic [3:0]           font_row,
  output logic                 dot
);

  logic [DW-1:0] dot_idx;
  logic [SW-1:0] col;
  logic          at_cursor;
  logic          underline;

  always_comb begin
    // Dots leave in descending order so the first one sent ends up furthest away.
    dot_idx   = DW'(TOT - 1) - DW'(pcnt >> 1);
    font_col  = CW'(dot_idx / DW'(CELL_COLS));
    col       = SW'(dot_idx % DW'(CELL_COLS));
    font_line = two_line ? next_row[3] : 1'b0;
    font_row  = two_line ? {1'b0, next_row[2:0]} : next_row[3:0];
    at_cursor = (font_col == cursor_col) && (font_line == cursor_line);
    underline = cursor_on && (font_row == underline_row(two_line, tall));
    dot = disp_on && (glyph[SW'(CELL_COLS - 1) - col]
                      || (at_cursor && underline)
                      || (at_cursor && blink_on && blink_ph));
  end

endmodule

// File: rtl/lcd_dot_serializer.sv
module lcd_dot_serializer #(
  parameter int SEG_BITS = 40,
  parameter int EXT_BITS = 40,
  parameter int PW       = 9,
  localparam int TOT = SEG_BITS + EXT_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PW-1:0]       pcnt,
  input  logic                dot,
  input  logic                row_end,
  output logic [SEG_BITS-1:0] seg,
  output logic                sdata,
  output logic                sclk
);

  logic [SEG_BITS-1:0] sreg;
  logic                in_burst;

  assign in_burst = (pcnt < PW'(2 * TOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      seg   <= '0;
      sdata <= 1'b0;
      sclk  <= 1'b0;
    end else begin
      // Even count: push a dot, present the bit falling off the end; odd count: clock it out.
      if (!pcnt[0] && in_burst) begin
        sreg  <= {sreg[SEG_BITS-2:0], dot};
        sdata <= sreg[SEG_BITS-1];
      end
      sclk <= pcnt[0] && in_burst;
      if (row_end) seg <= sreg;
    end
  end

endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int SEG_BITS     = 40,
  parameter int EXT_BITS     = 40,
  parameter int CELL_COLS    = 5,
  parameter int LONG_PERIOD  = 400,
  parameter int SHORT_PERIOD = 200,
  parameter int BLINK_FRAMES = 32,
  localparam int TOT = SEG_BITS + EXT_BITS,
  localparam int CW  = $clog2(TOT / CELL_COLS),
  localparam int PW  = $clog2(LONG_PERIOD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 two_line_i,
  input  logic                 tall_font_i,
  input  logic                 wave_b_i,
  input  logic                 disp_on_i,
  input  logic                 cursor_on_i,
  input  logic                 blink_on_i,
  input  logic [CW-1:0]        cursor_col_i,
  input  logic                 cursor_line_i,
  output logic [CW-1:0]        font_col_o,
  output logic                 font_line_o,
  output logic [3:0]           font_row_o,
  input  logic [CELL_COLS-1:0] glyph_i,
  output logic [MAX_COM-1:0]   com_o,
  output logic [SEG_BITS-1:0]  seg_o,
  output logic                 ext_data_o,
  output logic                 ext_shift_o,
  output logic                 ext_latch_o,
  output logic                 m_o
);

  logic [PW-1:0] pcnt;
  logic [4:0]    next_row;
  logic          row_end;
  logic          blink_ph;
  logic          dot;

  lcd_scan_timer #(
    .LONG_PERIOD (LONG_PERIOD),
    .SHORT_PERIOD(SHORT_PERIOD),
    .BLINK_FRAMES(BLINK_FRAMES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .two_line(two_line_i),
    .tall    (tall_font_i),
    .wave_b  (wave_b_i),
    .pcnt    (pcnt),
    .next_row(next_row),
    .row_end (row_end),
    .blink_ph(blink_ph),
    .com     (com_o),
    .m       (m_o),
    .latch   (ext_latch_o)
  );

  lcd_dot_composer #(
    .TOT      (TOT),
    .CELL_COLS(CELL_COLS),
    .PW       (PW)
  ) u_compose (
    .pcnt       (pcnt),
    .next_row   (next_row),
    .two_line   (two_line_i),
    .tall       (tall_font_i),
    .disp_on    (disp_on_i),
    .cursor_on  (cursor_on_i),
    .blink_on   (blink_on_i),
    .blink_ph   (blink_ph),
    .cursor_col (cursor_col_i),
    .cursor_line(cursor_line_i),
    .glyph      (glyph_i),
    .font_col   (font_col_o),
    .font_line  (font_line_o),
    .font_row   (font_row_o),
    .dot        (dot)
  );

  lcd_dot_serializer #(
    .SEG_BITS(SEG_BITS),
    .EXT_BITS(EXT_BITS),
    .PW      (PW)
  ) u_serial (
    .clk    (clk),
    .rst    (rst),
    .pcnt   (pcnt),
    .dot    (dot),
    .row_end(row_end),
    .seg    (seg_o),
    .sdata  (ext_data_o),
    .sclk   (ext_shift_o)
  );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] com_o,
  input logic        ext_latch_o,
  input logic        ext_shift_o,
  input logic        ext_data_o,
  input logic        m_o
);

  // R2
  com_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(com_o) == 1);

  // R2
  com_advance_chk: assert property (@(posedge clk) disable iff (rst)
    ext_latch_o |-> (com_o == ($past(com_o) << 1)) || (com_o == 16'd1));

  // R7
  com_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(com_o) |-> ext_latch_o);

  // R7
  latch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ext_latch_o |=> !ext_latch_o);

  // R6
  shift_rate_chk: assert property (@(posedge clk) disable iff (rst)
    ext_shift_o |=> !ext_shift_o);

  // R8
  data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ext_data_o) |-> !ext_shift_o);

  // R9
  m_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_o) |-> ext_latch_o);

endmodule

bind lcd_scan_top lcd_scan_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .com_o      (com_o),
  .ext_latch_o(ext_latch_o),
  .ext_shift_o(ext_shift_o),
  .ext_data_o (ext_data_o),
  .m_o        (m_o)
);

// File: tb/lcd_scan_top_test.sv
module lcd_scan_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 10;
  localparam int NEXT  = 10;
  localparam int COLS  = 5;
  localparam int LONGP = 48;
  localparam int SHORTP = 44;
  localparam int BLINK = 2;
  localparam int TOT   = NSEG + NEXT;
  localparam int CW    = $clog2(TOT / COLS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic two_line = 0, tall = 0, wave_b = 0, disp_on = 1, cur_on = 0, blink_on = 0;
  logic [CW-1:0] ccol = '0;
  logic cline = 0;
  logic [CW-1:0] font_col;
  logic font_line;
  logic [3:0] font_row;
  logic [COLS-1:0] glyph;
  logic [15:0] com;
  logic [NSEG-1:0] seg;
  logic ext_data, ext_shift, ext_latch, m;

  logic [NEXT-1:0] ext_sr, ext_lat;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [COLS-1:0] font_fn(input int c, input int l, input int r);
    return COLS'((c * 11 + l * 7 + r * 3 + 5) ^ (r * 4));
  endfunction

  assign glyph = font_fn(int'(font_col), int'(font_line), int'(font_row));

  lcd_scan_top #(
    .SEG_BITS(NSEG), .EXT_BITS(NEXT), .CELL_COLS(COLS),
    .LONG_PERIOD(LONGP), .SHORT_PERIOD(SHORTP), .BLINK_FRAMES(BLINK)
  ) uut (
    .clk(clk), .rst(rst), .two_line_i(two_line), .tall_font_i(tall),
    .wave_b_i(wave_b), .disp_on_i(disp_on), .cursor_on_i(cur_on),
    .blink_on_i(blink_on), .cursor_col_i(ccol), .cursor_line_i(cline),
    .font_col_o(font_col), .font_line_o(font_line), .font_row_o(font_row),
    .glyph_i(glyph), .com_o(com), .seg_o(seg), .ext_data_o(ext_data),
    .ext_shift_o(ext_shift), .ext_latch_o(ext_latch), .m_o(m)
  );

  // Model of a cascaded extension driver.
  always @(posedge ext_shift) ext_sr <= {ext_sr[NEXT-2:0], ext_data};
  always @(posedge ext_latch) ext_lat <= ext_sr;

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ncom();
    return two_line ? 16 : (tall ? 11 : 8);
  endfunction

  function automatic int period();
    return two_line ? SHORTP : LONGP;
  endfunction

  // Expected dot j of scan row k with blink phase ph (R4, R10, R11, R12).
  function automatic bit exp_dot(input int k, input int j, input int ph);
    int line, row, ch, col, last;
    logic [COLS-1:0] g;
    bit b, cur;
    line = two_line ? k / 8 : 0;
    row  = two_line ? k % 8 : k;
    ch   = j / COLS;
    col  = j % COLS;
    g    = font_fn(ch, line, row);
    b    = g[COLS - 1 - col];
    cur  = (ch == int'(ccol)) && (line == int'(cline));
    last = (two_line || !tall) ? 7 : 10;
    if (cur && cur_on && row == last) b = 1;
    if (cur && blink_on && ph == 1) b = 1;
    return disp_on && b;
  endfunction

  task automatic run_mode(input int frames);
    int p, nc, n, k, ph;
    logic [NSEG-1:0] es;
    logic [NEXT-1:0] ee;
    p  = period();
    nc = ncom();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 com", com, 1);
    check("R1 seg", seg, 0);
    check("R1 ctl", {m, ext_shift, ext_latch, ext_data}, 0);
    rst = 1'b0;
    for (int t = 0; t < frames * p * nc; t++) begin
      @(negedge clk);
      n = (t + 1) / p;
      if (t == 0) check("R1 first", {com, m, ext_latch}, {16'd1, 2'b00});
      // R2, R3: active common
      check("R2/R3 com", com, 16'd1 << (n % nc));
      // R9 alternation
      check("R9 m", m, wave_b ? ((t + 1) / (p * nc)) % 2 : n % 2);
      // R7 latch pulse
      check("R7 latch", ext_latch, ((t + 1) % p) == 0);
      // R6 shift clock
      check("R6 shift", ext_shift, ((t % p) % 2 == 1) && ((t % p) < 2 * TOT));
      if (((t + 1) % p) == 0) begin
        k  = n % nc;
        ph = (((n - 1) / nc) / BLINK) % 2;
        for (int j = 0; j < NSEG; j++) es[j] = exp_dot(k, j, ph);
        for (int j = 0; j < NEXT; j++) ee[j] = exp_dot(k, NSEG + j, ph);
        // R4, R10, R11, R12 segment latch
        check("R4 seg", seg, es);
        // R5 extension data
        check("R5 ext", ext_lat, ee);
      end
    end
  endtask

  initial begin
    // 1-line 5x8, per-row alternation, underline at column 1
    two_line = 0; tall = 0; wave_b = 0; disp_on = 1; cur_on = 1; blink_on = 0;
    ccol = 2'd1; cline = 0;
    run_mode(3);
    // 1-line 5x11, per-frame alternation, underline plus blink at column 3 (R11, R12)
    two_line = 0; tall = 1; wave_b = 1; cur_on = 1; blink_on = 1; ccol = 2'd3;
    run_mode(5);
    // 2-line, cursor on second line
    two_line = 1; tall = 0; wave_b = 0; cur_on = 1; blink_on = 1; ccol = 2'd0; cline = 1;
    run_mode(5);
    // blink only, no underline
    two_line = 0; tall = 0; wave_b = 1; cur_on = 0; blink_on = 1; ccol = 2'd2; cline = 0;
    run_mode(4);
    // R10 display off
    two_line = 1; wave_b = 1; disp_on = 0; cur_on = 1; blink_on = 1;
    run_mode(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule